// File: doc/BRIEF.md
# Mixed-Length Instruction Fetch Realigner

This block sits between a fetch unit that delivers 32-bit words and an instruction decoder for an instruction set where 16-bit compressed and 32-bit instructions are packed back to back on halfword boundaries. It takes one fetch word per handshake and keeps its own program counter, which is loaded by a control-flow redirect. It hands the decoder one complete instruction at a time, together with its address, a compressed flag, the next sequential address and an illegal flag.

The length of each instruction is set by its lowest two bits. A 32-bit instruction that begins in the upper half of a fetch word is held and completed from the lower half of the next word. The upper half of a word whose lower half was a compressed instruction is kept, so that it is used without another fetch. The fetch word presented on `fetch_word` must be the word at the current program counter rounded down to a multiple of 4. After each accepted word the fetch side moves on to the next word. After a redirect it restarts at the new target rounded down to a multiple of 4.

Top module: `cinst_realigner`

## Requirements
- R1: A halfword whose bits [1:0] are not 2'b11 starts a 16-bit instruction, and `out_short` is 1 for it. Bits [1:0] equal to 2'b11 start a 32-bit instruction, and `out_short` is 0 for it.
- R2: When the program counter is a multiple of 4 and the low halfword of the fetch word is short, that halfword is emitted with bits [31:16] of `out_inst` set to zero. The upper halfword of the same word is then processed without another fetch.
- R3: When the program counter is a multiple of 4 and the low halfword starts a 32-bit instruction, the whole fetch word is emitted as the instruction.
- R4: When the program counter is 2 mod 4 and the upper halfword is short, the upper halfword is emitted zero-extended.
- R5: When the program counter is 2 mod 4 and the upper halfword starts a 32-bit instruction, nothing is emitted. `out_valid` stays 0 and `need_more` stays 1 until the next word arrives.
- R6: The instruction held in R5 is completed with the next fetch word's low halfword as bits [31:16]. It is emitted with its first halfword's address, and decoding then continues with that word's upper halfword.
- R7: `out_next_pc` equals `out_pc` plus 2 for a short instruction and plus 4 for a 32-bit one.
- R8: After reset, `out_valid` is 0, `need_more` and `fetch_ready` are 1, `out_inst` holds the no-operation word 32'h0000_0013, and the program counter is `RESET_PC`.
- R9: An emitted instruction that is all zeros has `out_illegal` set to 1. Every other instruction has it at 0.
- R10: An emitted instruction stays on the outputs, unchanged, until `out_take` is high while `out_valid` is 1. In that cycle it is consumed, and `out_valid` falls on the next edge unless a new instruction is loaded.
- R11: `redirect` discards the pending output, any held halfword and any partial instruction. It loads the program counter from `redirect_pc`, with bit 0 forced to 0, and alignment restarts from bit 1 of that address.
- R12: A fetch word is accepted only in a cycle with `fetch_valid` and `fetch_ready` both high. `fetch_ready` is 0 while a kept upper halfword is still unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect | input | 1 | Control-flow redirect, flushes all held state |
| redirect_pc | input | PC_W | New program counter for a redirect |
| fetch_valid | input | 1 | A fetch word is offered |
| fetch_word | input | 32 | Fetch word at the current PC rounded down to 4 |
| fetch_ready | output | 1 | The offered fetch word is accepted this cycle |
| need_more | output | 1 | No kept halfword is pending, so a new word is needed to progress |
| out_valid | output | 1 | A complete instruction is on the outputs |
| out_take | input | 1 | The decoder consumes the instruction |
| out_inst | output | 32 | Instruction, zero-extended when short |
| out_short | output | 1 | Instruction is 16 bits |
| out_pc | output | PC_W | Address of the instruction |
| out_next_pc | output | PC_W | Next sequential address |
| out_illegal | output | 1 | Instruction is all zeros |

## Verification
The assertions check the following on every clock:
- a short output never carries upper bits;
- the next-address offset matches the length flag;
- a held output does not change;
- a consumed output drops when nothing replaces it;
- entering the mid-instruction state leaves the output empty while words are still requested;
- a redirect empties the output and the mid state.

Only the bench's scenarios can show that whole streams come out in the right order with the right addresses. These are random mixes of both lengths, with words straddling boundaries, start points on both alignments and random stalls on both sides. The same holds for the reuse of a kept upper halfword without a fetch, and for a flush that drops a half-built instruction.

// File: rtl/cr_pkg.sv
package cr_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam logic [WORD_W-1:0] NOP_WORD = 32'h0000_0013;

  // a halfword opens a 16-bit instruction unless its two low bits are both set
  function automatic logic half_is_short(input logic [HALF_W-1:0] h);
    return h[1:0] != 2'b11;
  endfunction

  // byte distance to the following instruction
  function automatic logic [2:0] step_bytes(input logic short_inst);
    return short_inst ? 3'd2 : 3'd4;
  endfunction

  function automatic logic word_is_zero(input logic [WORD_W-1:0] w);
    return w == '0;
  endfunction

endpackage

// File: rtl/cr_assemble.sv
module cr_assemble
  import cr_pkg::*;
(
  input  logic [WORD_W-1:0] src_word,
  input  logic              use_upper,
  input  logic              mid,
  input  logic [HALF_W-1:0] mid_half,
  output logic              emit,
  output logic              enter_mid,
  output logic              keep_upper,
  output logic              inst_short,
  output logic [WORD_W-1:0] inst,
  output logic [HALF_W-1:0] pick_half
);

  logic [HALF_W-1:0] lo_half;
  logic [HALF_W-1:0] hi_half;

  assign lo_half   = src_word[HALF_W-1:0];
  assign hi_half   = src_word[WORD_W-1:HALF_W];
  assign pick_half = use_upper ? hi_half : lo_half;

  always_comb begin
    emit       = 1'b0;
    enter_mid  = 1'b0;
    keep_upper = 1'b0;
    inst_short = 1'b0;
    inst       = '0;
    if (mid) begin
      // second half of a straddling instruction
      emit       = 1'b1;
      keep_upper = 1'b1;
      inst       = {lo_half, mid_half};
    end else if (!use_upper) begin
      emit = 1'b1;
      if (half_is_short(lo_half)) begin
        inst_short = 1'b1;
        keep_upper = 1'b1;
        inst       = {{HALF_W{1'b0}}, lo_half};
      end else begin
        inst = src_word;
      end
    end else begin
      if (half_is_short(hi_half)) begin
        emit       = 1'b1;
        inst_short = 1'b1;
        inst       = {{HALF_W{1'b0}}, hi_half};
      end else begin
        enter_mid = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cr_out_reg.sv
module cr_out_reg
  import cr_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic              take,
  input  logic [WORD_W-1:0] in_inst,
  input  logic              in_short,
  input  logic [PC_W-1:0]   in_pc,
  output logic              slot_free,
  output logic              valid,
  output logic [WORD_W-1:0] inst,
  output logic              short_inst,
  output logic [PC_W-1:0]   pc,
  output logic [PC_W-1:0]   next_pc,
  output logic              illegal
);

  assign slot_free = !valid || take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid      <= 1'b0;
      inst       <= NOP_WORD;
      short_inst <= 1'b0;
      pc         <= '0;
      next_pc    <= '0;
      illegal    <= 1'b0;
    end else if (flush) begin
      valid <= 1'b0;
    end else if (load) begin
      valid      <= 1'b1;
      inst       <= in_inst;
      short_inst <= in_short;
      pc         <= in_pc;
      next_pc    <= in_pc + PC_W'(step_bytes(in_short));
      illegal    <= word_is_zero(in_inst);
    end else if (take) begin
      valid <= 1'b0;
    end
  end

  AST_READY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    valid && take && !load && !flush |=> !valid); // R10
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !take && !flush |=> valid && $stable(inst) && $stable(pc)); // R10

endmodule

// File: rtl/cinst_realigner.sv
module cinst_realigner
  import cr_pkg::*;
#(
  parameter int unsigned PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect,
  input  logic [PC_W-1:0]   redirect_pc,
  input  logic              fetch_valid,
  input  logic [WORD_W-1:0] fetch_word,
  output logic              fetch_ready,
  output logic              need_more,
  output logic              out_valid,
  input  logic              out_take,
  output logic [WORD_W-1:0] out_inst,
  output logic              out_short,
  output logic [PC_W-1:0]   out_pc,
  output logic [PC_W-1:0]   out_next_pc,
  output logic              out_illegal
);

  logic [PC_W-1:0]   cur_pc;
  logic [WORD_W-1:0] kept_word;
  logic              kept_upper;
  logic              mid_q;
  logic [HALF_W-1:0] mid_half;

  logic              slot_free;
  logic              fetch_fire;
  logic              step;
  logic [WORD_W-1:0] src_word;
  logic              a_emit, a_enter_mid, a_keep_upper, a_short;
  logic [WORD_W-1:0] a_inst;
  logic [HALF_W-1:0] a_half;
  logic              load_out;
  logic              enter_mid;

  assign fetch_ready = !kept_upper && slot_free && !redirect;
  assign fetch_fire  = fetch_valid && fetch_ready;
  assign need_more   = !kept_upper;
  assign step        = !redirect && slot_free && (kept_upper || fetch_fire);
  assign src_word    = kept_upper ? kept_word : fetch_word;

  cr_assemble i_asm (
    .src_word   (src_word),
    .use_upper  (cur_pc[1]),
    .mid        (mid_q),
    .mid_half   (mid_half),
    .emit       (a_emit),
    .enter_mid  (a_enter_mid),
    .keep_upper (a_keep_upper),
    .inst_short (a_short),
    .inst       (a_inst),
    .pick_half  (a_half)
  );

  assign load_out  = step && a_emit;
  assign enter_mid = step && a_enter_mid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_pc     <= RESET_PC;
      kept_word  <= '0;
      kept_upper <= 1'b0;
      mid_q      <= 1'b0;
      mid_half   <= '0;
    end else if (redirect) begin
      cur_pc     <= {redirect_pc[PC_W-1:1], 1'b0};
      kept_upper <= 1'b0;
      mid_q      <= 1'b0;
    end else if (step) begin
      if (a_emit) begin
        cur_pc <= cur_pc + PC_W'(step_bytes(a_short));
      end
      kept_upper <= a_keep_upper;
      if (a_keep_upper) begin
        kept_word <= src_word;
      end
      mid_q <= a_enter_mid;
      if (a_enter_mid) begin
        mid_half <= a_half;
      end
    end
  end

  cr_out_reg #(.PC_W(PC_W)) i_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (redirect),
    .load       (load_out),
    .take       (out_take),
    .in_inst    (a_inst),
    .in_short   (a_short),
    .in_pc      (cur_pc),
    .slot_free  (slot_free),
    .valid      (out_valid),
    .inst       (out_inst),
    .short_inst (out_short),
    .pc         (out_pc),
    .next_pc    (out_next_pc),
    .illegal    (out_illegal)
  );

  AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_short |-> out_inst[WORD_W-1:HALF_W] == '0); // R2
  AST_NEXT_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_next_pc - out_pc) == (out_short ? PC_W'(2) : PC_W'(4))); // R7
  AST_MID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    enter_mid |=> !out_valid && need_more); // R5
  AST_REDIRECT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !out_valid && !mid_q && need_more); // R11
  AST_NO_FETCH_WHILE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !need_more |-> !fetch_ready); // R12

endmodule

// File: tb/test_cinst_realigner.sv
module test_cinst_realigner;

  localparam int MEMH = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redirect = 1'b0;
  logic [31:0] redirect_pc = '0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_word = '0;
  logic        fetch_ready;
  logic        need_more;
  logic        out_valid;
  logic        out_take = 1'b0;
  logic [31:0] out_inst;
  logic        out_short;
  logic [31:0] out_pc;
  logic [31:0] out_next_pc;
  logic        out_illegal;

  always #2 clk = ~clk;

  cinst_realigner #(.PC_W(32), .RESET_PC(32'h0)) i_cinst_realigner (
    .clk(clk), .rst_n(rst_n), .redirect(redirect), .redirect_pc(redirect_pc),
    .fetch_valid(fetch_valid), .fetch_word(fetch_word), .fetch_ready(fetch_ready),
    .need_more(need_more), .out_valid(out_valid), .out_take(out_take),
    .out_inst(out_inst), .out_short(out_short), .out_pc(out_pc),
    .out_next_pc(out_next_pc), .out_illegal(out_illegal)
  );

  typedef struct { logic [31:0] inst; logic [31:0] pc; logic sh; } exp_t;

  logic [15:0] mem [MEMH];
  exp_t        q[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] fa = '0;
  logic        prev_hold = 1'b0;
  logic [31:0] prev_inst = '0;

  function automatic logic [15:0] rd(input logic [31:0] a);
    return mem[(a >> 1) % MEMH];
  endfunction

  task automatic wr(input logic [31:0] a, input logic [15:0] v);
    mem[(a >> 1) % MEMH] = v;
  endtask

  task automatic check(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // walk memory from a start address and list the instructions in program order
  task automatic build_expect(input logic [31:0] start, input int k);
    logic [31:0] a = start;
    q.delete();
    for (int i = 0; i < k; i++) begin
      exp_t e;
      logic [15:0] h = rd(a);
      e.pc = a;
      if (h[1:0] != 2'b11) begin
        e.inst = {16'h0, h}; e.sh = 1'b1; a = a + 2;
      end else begin
        e.inst = {rd(a + 2), h}; e.sh = 1'b0; a = a + 4;
      end
      q.push_back(e);
    end
  endtask

  // lay down a random mix of instruction lengths starting at a
  task automatic gen_prog(input logic [31:0] a0, input int k);
    logic [31:0] a = a0;
    for (int i = 0; i < k; i++) begin
      logic [31:0] r = $urandom;
      int sel = int'($urandom % 8);
      if (sel == 0) begin
        wr(a, 16'h0000); a = a + 2;
      end else if (sel < 4) begin
        wr(a, {r[15:2], 2'(r[17:16] % 3)}); a = a + 2;
      end else begin
        wr(a, {r[15:2], 2'b11}); wr(a + 2, r[31:16]); a = a + 4;
      end
    end
  endtask

  task automatic do_redirect(input logic [31:0] pc);
    @(negedge clk);
    redirect = 1'b1; redirect_pc = pc; fetch_valid = 1'b0; out_take = 1'b0;
    @(negedge clk);
    redirect = 1'b0;
    fa = pc & 32'hFFFF_FFFC;
    prev_hold = 1'b0;
    #1;
    check(!out_valid, "R11 output empty after redirect", {31'h0, out_valid}, 32'h0);
  endtask

  // one cycle: offer word fv, take output tk; sample the results after the next edge
  task automatic one_cycle(input logic fv, input logic tk);
    @(negedge clk);
    fetch_valid = fv; out_take = tk; fetch_word = {rd(fa + 2), rd(fa)};
    #1;
    if (fetch_valid && fetch_ready) fa = fa + 4;
    @(negedge clk);
    fetch_valid = 1'b0; out_take = 1'b0;
    #1;
  endtask

  task automatic cmp_out(input exp_t e, input string tag);
    check(out_inst == e.inst, {tag, " R2 R3 R4 R6 inst"}, out_inst, e.inst);
    check(out_pc == e.pc, {tag, " R6 pc"}, out_pc, e.pc);
    check(out_short == e.sh, {tag, " R1 short flag"}, {31'h0, out_short}, {31'h0, e.sh});
    check(out_next_pc == e.pc + (e.sh ? 32'd2 : 32'd4), {tag, " R7 next pc"}, out_next_pc,
          e.pc + (e.sh ? 32'd2 : 32'd4));
    check(out_illegal == (e.inst == 32'h0), {tag, " R9 illegal"}, {31'h0, out_illegal},
          {31'h0, e.inst == 32'h0});
  endtask

  task automatic run_stream(input logic [31:0] start, input int k);
    gen_prog(start, k);
    build_expect(start, k);
    do_redirect(start);
    while (q.size() != 0) begin
      @(negedge clk);
      redirect = 1'b0;
      fetch_valid = ($urandom % 4) != 0;
      out_take = ($urandom % 3) != 0;
      fetch_word = {rd(fa + 2), rd(fa)};
      #1;
      if (prev_hold) begin
        check(out_valid && out_inst == prev_inst, "R10 held output stable", out_inst, prev_inst);
      end
      if (fetch_valid && fetch_ready) fa = fa + 4;
      if (out_valid && out_take) begin
        exp_t e = q.pop_front();
        cmp_out(e, "stream");
      end
      prev_hold = out_valid && !out_take;
      prev_inst = out_inst;
    end
    @(negedge clk);
    fetch_valid = 1'b0; out_take = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    exp_t e;
    for (int i = 0; i < MEMH; i++) mem[i] = 16'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!out_valid, "R8 reset out_valid", {31'h0, out_valid}, 32'h0);
    check(need_more, "R8 reset need_more", {31'h0, need_more}, 32'h1);
    check(fetch_ready, "R8 reset fetch_ready", {31'h0, fetch_ready}, 32'h1);
    check(out_inst == 32'h0000_0013, "R8 reset nop", out_inst, 32'h0000_0013);

    // R8: fetch starts at RESET_PC = 0 with no redirect
    wr(32'h0, 16'h4501); wr(32'h2, 16'h0093);
    fa = 32'h0;
    one_cycle(1'b1, 1'b0);
    check(out_valid && out_pc == 32'h0, "R8 first pc after reset", out_pc, 32'h0);

    // R2 / R12: a pair of short instructions in one word
    wr(32'h100, 16'h4505); wr(32'h102, 16'h8082);
    do_redirect(32'h100);
    one_cycle(1'b1, 1'b0);
    e = '{inst: 32'h0000_4505, pc: 32'h100, sh: 1'b1};
    cmp_out(e, "pair low");
    check(!fetch_ready, "R12 fetch_ready low with kept upper", {31'h0, fetch_ready}, 32'h0);
    check(!need_more, "R2 no fetch needed for upper", {31'h0, need_more}, 32'h0);
    one_cycle(1'b0, 1'b1);
    e = '{inst: 32'h0000_8082, pc: 32'h102, sh: 1'b1};
    check(out_valid, "R2 upper emitted without fetch", {31'h0, out_valid}, 32'h1);
    cmp_out(e, "pair high");
    check(need_more, "R2 need_more after upper used", {31'h0, need_more}, 32'h1);
    one_cycle(1'b0, 1'b1);
    check(!out_valid, "R10 valid clears after take", {31'h0, out_valid}, 32'h0);

    // R3: aligned full-width word
    wr(32'h140, 16'h0513); wr(32'h142, 16'h00A0);
    do_redirect(32'h140);
    one_cycle(1'b1, 1'b0);
    e = '{inst: 32'h00A0_0513, pc: 32'h140, sh: 1'b0};
    cmp_out(e, "aligned full");
    check(need_more, "R3 next word requested", {31'h0, need_more}, 32'h1);

    // R4: unaligned short
    wr(32'h180, 16'hFFFF); wr(32'h182, 16'h4185);
    do_redirect(32'h182);
    one_cycle(1'b1, 1'b0);
    e = '{inst: 32'h0000_4185, pc: 32'h182, sh: 1'b1};
    cmp_out(e, "unaligned short");

    // R5 / R6: straddling instruction
    wr(32'h200, 16'h1111); wr(32'h202, 16'h0593); wr(32'h204, 16'h0010); wr(32'h206, 16'h0000);
    do_redirect(32'h202);
    one_cycle(1'b1, 1'b1);
    check(!out_valid, "R5 nothing emitted in mid state", {31'h0, out_valid}, 32'h0);
    check(need_more, "R5 more bytes requested", {31'h0, need_more}, 32'h1);
    one_cycle(1'b1, 1'b0);
    e = '{inst: 32'h0010_0593, pc: 32'h202, sh: 1'b0};
    cmp_out(e, "straddle");
    one_cycle(1'b0, 1'b1);
    e = '{inst: 32'h0000_0000, pc: 32'h206, sh: 1'b1};
    cmp_out(e, "R6 continue upper / R9 zero");

    // R11: redirect drops a half-built instruction
    do_redirect(32'h202);
    one_cycle(1'b1, 1'b1);
    wr(32'h300, 16'h4581); wr(32'h302, 16'h4601);
    do_redirect(32'h300);
    one_cycle(1'b1, 1'b0);
    e = '{inst: 32'h0000_4581, pc: 32'h300, sh: 1'b1};
    cmp_out(e, "R11 after flush");

    // random mixed streams on both alignments, with stalls on both sides
    for (int s = 0; s < 40; s++) begin
      logic [31:0] st = 32'h400 + 32'(($urandom % 64) * 2);
      run_stream(st, 20 + int'($urandom % 40));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule